// File: doc/BRIEF.md
# RV32I Instruction Decoder with Immediate Generation

This block is a purely combinational front-end decoder for a 32-bit base integer RISC-V core. It takes one instruction word and sorts it by major opcode into one of nine classes: register-register arithmetic, register-immediate arithmetic, load, store, conditional branch, the two jumps, and the two upper-immediate instructions. Any other opcode raises an illegal flag.

Alongside the class it splits out the register specifiers and the function fields, and it builds the 32-bit sign-extended immediate in whichever of the five immediate layouts the opcode uses. The branch and jump layouts scatter their bits across the word, and the block puts them back in order. It also gives a format code and three enables that tell the register file which ports the instruction uses.

The outputs feed a decode stage directly. The block holds no state, so any pipeline register belongs to the surrounding stage.

Top module: `rv32i_instr_decode`

## Requirements
- R1: `op_class_o` encodes the opcode held in `instr_i[6:0]`: 0110011→0, 0010011→1, 0000011→2, 0100011→3, 1100011→4, 1101111→5, 1100111→6, 0110111→7, 0010111→8, and `illegal_o` is 0 for these nine opcodes.
- R2: Any other value of `instr_i[6:0]` sets `illegal_o` to 1, `op_class_o` to 15 and `imm_fmt_o` to 7. All three enables are 0 and `imm_o` is 0.
- R3: `rd_o`=`instr_i[11:7]`, `rs1_o`=`instr_i[19:15]`, `rs2_o`=`instr_i[24:20]`, `funct3_o`=`instr_i[14:12]` and `funct7_o`=`instr_i[31:25]` for every instruction word, whether legal or not.
- R4: For classes 1, 2 and 6, `imm_o` is `instr_i[31:20]` sign-extended.
- R5: For class 3, `imm_o` is {`instr_i[31:25]`, `instr_i[11:7]`} sign-extended.
- R6: For class 4, `imm_o` is {`instr_i[31]`, `instr_i[7]`, `instr_i[30:25]`, `instr_i[11:8]`, 0} sign-extended, so bit 0 is always 0.
- R7: For classes 7 and 8, `imm_o[31:12]` is `instr_i[31:12]` and `imm_o[11:0]` is 0.
- R8: For class 5, `imm_o` is {`instr_i[31]`, `instr_i[19:12]`, `instr_i[20]`, `instr_i[30:21]`, 0} sign-extended, so bit 0 is always 0.
- R9: Every immediate takes its sign from `instr_i[31]`. For class 0, which has no immediate, `imm_o` is 0.
- R10: `imm_fmt_o` is 0 for class 0, 1 for classes 1, 2 and 6, 2 for class 3, 3 for class 4, 4 for classes 7 and 8, and 5 for class 5.
- R11: `rs1_rd_en_o` is 1 for classes 0, 1, 2, 3, 4 and 6. `rs2_rd_en_o` is 1 only for classes 0, 3 and 4. `rd_wr_en_o` is 1 for every legal class except 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| op_class_o | output | 4 | Opcode class code, 15 when illegal |
| imm_fmt_o | output | 3 | Immediate layout code, 7 when illegal |
| illegal_o | output | 1 | Opcode is not one of the nine supported |
| rd_o | output | 5 | Destination register specifier |
| rs1_o | output | 5 | First source register specifier |
| rs2_o | output | 5 | Second source register specifier |
| funct3_o | output | 3 | Minor function field |
| funct7_o | output | 7 | Upper function field |
| imm_o | output | 32 | Sign-extended immediate |
| rs1_rd_en_o | output | 1 | Instruction reads the first source register |
| rs2_rd_en_o | output | 1 | Instruction reads the second source register |
| rd_wr_en_o | output | 1 | Instruction writes the destination register |

## Verification
The assertions check, for every instruction word, a set of rules that hold across outputs. The illegal flag agrees with the class code and keeps the enables and the immediate quiet. Branch and jump immediates are even, and upper immediates have zero low bits. The sign of every immediate follows bit 31, and stores and branches never write a register. Only the bench's vectors show that each scattered bit lands at its exact place in the immediate: a branch whose bit 7 alone is set, a jump whose bit 20 or bit 12 alone is set, and the extreme offsets. A sweep over all 128 opcode values shows that exactly the nine supported opcodes decode as legal.

// File: rtl/rv32i_instr_decode.sv
module rv32i_instr_decode (
  input  logic [31:0] instr_i,
  output logic [3:0]  op_class_o,
  output logic [2:0]  imm_fmt_o,
  output logic        illegal_o,
  output logic [4:0]  rd_o,
  output logic [4:0]  rs1_o,
  output logic [4:0]  rs2_o,
  output logic [2:0]  funct3_o,
  output logic [6:0]  funct7_o,
  output logic [31:0] imm_o,
  output logic        rs1_rd_en_o,
  output logic        rs2_rd_en_o,
  output logic        rd_wr_en_o
);

  localparam logic [6:0] OPC_REG    = 7'b0110011;
  localparam logic [6:0] OPC_IMM    = 7'b0010011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;

  localparam logic [3:0] CLS_REG    = 4'd0;
  localparam logic [3:0] CLS_IMM    = 4'd1;
  localparam logic [3:0] CLS_LOAD   = 4'd2;
  localparam logic [3:0] CLS_STORE  = 4'd3;
  localparam logic [3:0] CLS_BRANCH = 4'd4;
  localparam logic [3:0] CLS_JAL    = 4'd5;
  localparam logic [3:0] CLS_JALR   = 4'd6;
  localparam logic [3:0] CLS_LUI    = 4'd7;
  localparam logic [3:0] CLS_AUIPC  = 4'd8;
  localparam logic [3:0] CLS_NONE   = 4'd15;

  localparam logic [2:0] FMT_R    = 3'd0;
  localparam logic [2:0] FMT_I    = 3'd1;
  localparam logic [2:0] FMT_S    = 3'd2;
  localparam logic [2:0] FMT_B    = 3'd3;
  localparam logic [2:0] FMT_U    = 3'd4;
  localparam logic [2:0] FMT_J    = 3'd5;
  localparam logic [2:0] FMT_NONE = 3'd7;

  logic [6:0]  opc;
  logic        sgn;
  logic [31:0] imm_i, imm_s, imm_b, imm_u, imm_j;

  assign opc = instr_i[6:0];
  assign sgn = instr_i[31];

  assign rd_o     = instr_i[11:7];
  assign rs1_o    = instr_i[19:15];
  assign rs2_o    = instr_i[24:20];
  assign funct3_o = instr_i[14:12];
  assign funct7_o = instr_i[31:25];

  assign imm_i = {{20{sgn}}, instr_i[31:20]};
  assign imm_s = {{20{sgn}}, instr_i[31:25], instr_i[11:7]};
  assign imm_b = {{19{sgn}}, sgn, instr_i[7], instr_i[30:25], instr_i[11:8], 1'b0};
  assign imm_u = {instr_i[31:12], 12'h000};
  assign imm_j = {{11{sgn}}, sgn, instr_i[19:12], instr_i[20], instr_i[30:21], 1'b0};

  always_comb begin
    op_class_o  = CLS_NONE;
    imm_fmt_o   = FMT_NONE;
    rs1_rd_en_o = 1'b0;
    rs2_rd_en_o = 1'b0;
    rd_wr_en_o  = 1'b0;
    unique case (opc)
      OPC_REG: begin
        op_class_o = CLS_REG;    imm_fmt_o = FMT_R;
        rs1_rd_en_o = 1'b1; rs2_rd_en_o = 1'b1; rd_wr_en_o = 1'b1;
      end
      OPC_IMM: begin
        op_class_o = CLS_IMM;    imm_fmt_o = FMT_I;
        rs1_rd_en_o = 1'b1; rd_wr_en_o = 1'b1;
      end
      OPC_LOAD: begin
        op_class_o = CLS_LOAD;   imm_fmt_o = FMT_I;
        rs1_rd_en_o = 1'b1; rd_wr_en_o = 1'b1;
      end
      OPC_STORE: begin
        op_class_o = CLS_STORE;  imm_fmt_o = FMT_S;
        rs1_rd_en_o = 1'b1; rs2_rd_en_o = 1'b1;
      end
      OPC_BRANCH: begin
        op_class_o = CLS_BRANCH; imm_fmt_o = FMT_B;
        rs1_rd_en_o = 1'b1; rs2_rd_en_o = 1'b1;
      end
      OPC_JAL: begin
        op_class_o = CLS_JAL;    imm_fmt_o = FMT_J;
        rd_wr_en_o = 1'b1;
      end
      OPC_JALR: begin
        op_class_o = CLS_JALR;   imm_fmt_o = FMT_I;
        rs1_rd_en_o = 1'b1; rd_wr_en_o = 1'b1;
      end
      OPC_LUI: begin
        op_class_o = CLS_LUI;    imm_fmt_o = FMT_U;
        rd_wr_en_o = 1'b1;
      end
      OPC_AUIPC: begin
        op_class_o = CLS_AUIPC;  imm_fmt_o = FMT_U;
        rd_wr_en_o = 1'b1;
      end
      default: ;
    endcase
  end

  assign illegal_o = (op_class_o == CLS_NONE);

  always_comb begin
    case (imm_fmt_o)
      FMT_I:   imm_o = imm_i;
      FMT_S:   imm_o = imm_s;
      FMT_B:   imm_o = imm_b;
      FMT_U:   imm_o = imm_u;
      FMT_J:   imm_o = imm_j;
      default: imm_o = 32'h0;
    endcase
  end

endmodule

// File: rtl/rv32i_instr_decode_chk.sv
module rv32i_instr_decode_chk (
  input logic [31:0] instr_i,
  input logic [3:0]  op_class_o,
  input logic [2:0]  imm_fmt_o,
  input logic        illegal_o,
  input logic [31:0] imm_o,
  input logic        rs1_rd_en_o,
  input logic        rs2_rd_en_o,
  input logic        rd_wr_en_o
);

  always_comb begin
    if (!$isunknown(instr_i)) begin
      AST_ILLEGAL_CLASS: assert (illegal_o == (op_class_o == 4'd15)) else $error("illegal flag vs class"); // R1
      AST_ILLEGAL_QUIET: assert (!illegal_o || (imm_o == 32'h0 && !rs1_rd_en_o && !rs2_rd_en_o && !rd_wr_en_o && imm_fmt_o == 3'd7)) else $error("illegal not quiet"); // R2
      AST_B_EVEN: assert (imm_fmt_o != 3'd3 || imm_o[0] == 1'b0) else $error("branch offset odd"); // R6
      AST_U_LOW_ZERO: assert (imm_fmt_o != 3'd4 || imm_o[11:0] == 12'h000) else $error("upper imm low bits"); // R7
      AST_J_EVEN: assert (imm_fmt_o != 3'd5 || imm_o[0] == 1'b0) else $error("jump offset odd"); // R8
      AST_SIGN_BIT: assert (imm_fmt_o == 3'd0 || imm_fmt_o == 3'd7 || imm_o[31] == instr_i[31]) else $error("sign source"); // R9
      AST_NO_WRITE_SB: assert (!(op_class_o == 4'd3 || op_class_o == 4'd4) || !rd_wr_en_o) else $error("store/branch writes"); // R11
      AST_RS2_IMPLIES_RS1: assert (!rs2_rd_en_o || rs1_rd_en_o) else $error("rs2 without rs1"); // R11
    end
  end

endmodule

bind rv32i_instr_decode rv32i_instr_decode_chk u_chk (
  .instr_i     (instr_i),
  .op_class_o  (op_class_o),
  .imm_fmt_o   (imm_fmt_o),
  .illegal_o   (illegal_o),
  .imm_o       (imm_o),
  .rs1_rd_en_o (rs1_rd_en_o),
  .rs2_rd_en_o (rs2_rd_en_o),
  .rd_wr_en_o  (rd_wr_en_o)
);

// File: tb/rv32i_instr_decode_tb.sv
`timescale 1ns/1ps
module rv32i_instr_decode_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] instr;
  logic [3:0]  cls;
  logic [2:0]  fmt;
  logic        ill;
  logic [4:0]  rd, rs1, rs2;
  logic [2:0]  f3;
  logic [6:0]  f7;
  logic [31:0] imm;
  logic        e1, e2, ew;

  rv32i_instr_decode u_dut (
    .instr_i(instr), .op_class_o(cls), .imm_fmt_o(fmt), .illegal_o(ill),
    .rd_o(rd), .rs1_o(rs1), .rs2_o(rs2), .funct3_o(f3), .funct7_o(f7),
    .imm_o(imm), .rs1_rd_en_o(e1), .rs2_rd_en_o(e2), .rd_wr_en_o(ew)
  );

  typedef struct packed {
    logic [31:0] insn;
    logic [3:0]  cls;
    logic [2:0]  fmt;
    logic [2:0]  en;
    logic        ill;
    logic [31:0] imm;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{32'h002081B3, 4'd0,  3'd0, 3'b111, 1'b0, 32'h00000000}, // R1 R9 reg-reg
    '{32'hFFF30293, 4'd1,  3'd1, 3'b101, 1'b0, 32'hFFFFFFFF}, // R4 imm -1
    '{32'h80003013, 4'd1,  3'd1, 3'b101, 1'b0, 32'hFFFFF800}, // R4 most negative
    '{32'h7FF12503, 4'd2,  3'd1, 3'b101, 1'b0, 32'h000007FF}, // R4 load max
    '{32'hFE742E23, 4'd3,  3'd2, 3'b110, 1'b0, 32'hFFFFFFFC}, // R5 store -4
    '{32'h000000A3, 4'd3,  3'd2, 3'b110, 1'b0, 32'h00000001}, // R5 bit7 is imm bit0
    '{32'h00208463, 4'd4,  3'd3, 3'b110, 1'b0, 32'h00000008}, // R6 +8
    '{32'h000000E3, 4'd4,  3'd3, 3'b110, 1'b0, 32'h00000800}, // R6 bit7 is imm bit11
    '{32'hFE001FE3, 4'd4,  3'd3, 3'b110, 1'b0, 32'hFFFFFFFE}, // R6 -2
    '{32'h001000EF, 4'd5,  3'd5, 3'b001, 1'b0, 32'h00000800}, // R8 bit20 is imm bit11
    '{32'h0000106F, 4'd5,  3'd5, 3'b001, 1'b0, 32'h00001000}, // R8 bit12
    '{32'hFFFFF06F, 4'd5,  3'd5, 3'b001, 1'b0, 32'hFFFFFFFE}, // R8 -2
    '{32'h004280E7, 4'd6,  3'd1, 3'b101, 1'b0, 32'h00000004}, // R4 jalr
    '{32'h12345137, 4'd7,  3'd4, 3'b001, 1'b0, 32'h12345000}, // R7 lui
    '{32'hFFFFF197, 4'd8,  3'd4, 3'b001, 1'b0, 32'hFFFFF000}, // R7 auipc
    '{32'h0000000F, 4'd15, 3'd7, 3'b000, 1'b1, 32'h00000000}, // R2 fence opcode
    '{32'h00000073, 4'd15, 3'd7, 3'b000, 1'b1, 32'h00000000}, // R2 system opcode
    '{32'hFFFFFFFF, 4'd15, 3'd7, 3'b000, 1'b1, 32'h00000000}, // R2 all ones
    '{32'h00000032, 4'd15, 3'd7, 3'b000, 1'b1, 32'h00000000}  // R2 low bits not 11
  };

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s insn=%08h actual=%08h expected=%08h", req, instr, act, exp);
    end
  endtask

  task automatic chk_fields(input string req);
    chk(req, {27'd0, rd},  {27'd0, instr[11:7]});
    chk(req, {27'd0, rs1}, {27'd0, instr[19:15]});
    chk(req, {27'd0, rs2}, {27'd0, instr[24:20]});
    chk(req, {29'd0, f3},  {29'd0, instr[14:12]});
    chk(req, {25'd0, f7},  {25'd0, instr[31:25]});
  endtask

  function automatic bit is_legal(input logic [6:0] o);
    return o == 7'h33 || o == 7'h13 || o == 7'h03 || o == 7'h23 || o == 7'h63 ||
           o == 7'h6F || o == 7'h67 || o == 7'h37 || o == 7'h17;
  endfunction

  initial begin
    fork
      begin
        instr = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R2 reset", {31'd0, ill}, 32'd1);
        chk("R2 reset", {28'd0, cls}, 32'd15);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
          @(posedge clk); #1 instr = VECS[i].insn;
          @(negedge clk);
          chk("R1", {28'd0, cls}, {28'd0, VECS[i].cls});
          chk("R2", {31'd0, ill}, {31'd0, VECS[i].ill});
          chk("R10", {29'd0, fmt}, {29'd0, VECS[i].fmt});
          chk("R11", {29'd0, e1, e2, ew}, {29'd0, VECS[i].en});
          chk("R9 imm", imm, VECS[i].imm);
          chk_fields("R3");
        end

        @(posedge clk); #1 instr = 32'hA5A5A5A5;
        @(negedge clk);
        chk_fields("R3 illegal word");
        chk("R2 imm quiet", imm, 32'h0);

        for (int op = 0; op < 128; op++) begin
          @(posedge clk); #1 instr = {25'h15A5A5A, op[6:0]};
          @(negedge clk);
          chk("R1 R2 sweep", {31'd0, ill}, {31'd0, !is_legal(op[6:0])});
          if (!is_legal(op[6:0])) chk("R2 sweep quiet", {29'd0, e1, e2, ew}, 32'd0);
        end
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule